// File: doc/BRIEF.md
# Slow-bus memory window bridge

This block lets an 8-bit processor with an asynchronous, roughly 1 MHz bus see a 32 KB window of a large shared 32-bit memory. Each bus access that decodes inside the window becomes a word-aligned transaction on a pipelined bus master. The master tolerates stall and read data that arrives several cycles late. The shared bus carries whole 32-bit words and has no byte enables. A slow-bus read therefore fetches the word and returns one byte lane. A slow-bus write becomes a read, a merge of one byte into the word, and a write back to the same address.

The host processor reserves a buffer in software. It then loads the buffer address into a base register through a small single-register slave port. The window's position in shared memory can be changed at run time. The slow-bus strobe is synchronised into the system clock. Address, data and direction are sampled once in each strobe-high phase. A read result is driven back on the slow bus until the strobe falls.

Top module: `retro_window_bridge`

## Requirements
- R1: After reset, `mem_cyc` and `mem_stb` are low, `cpu_data_oe` is low, and the base register reads back as zero.
- R2: A write on the config port stores `cfg_wdata` with bits [1:0] forced to zero. A read returns that value. `cfg_ack` is high for exactly one cycle, one cycle after `cfg_cyc` and `cfg_stb` go high.
- R3: A slow-bus address outside the range WIN_LO to WIN_LO+32K-1 (default 0x8000 to 0xFFFF) starts no memory request, never raises `cpu_data_oe`, and leaves memory unchanged.
- R4: A slow-bus read at address A in the window requests the memory byte address ((base + A - WIN_LO) with bits [1:0] cleared) with `mem_we` low. It then drives byte lane n = A[1:0], meaning bits [8n+7:8n] of the returned word, on `cpu_data_out` with `cpu_data_oe` high. `cpu_data_oe` stays high until the synchronised strobe falls, and it is high only while no memory cycle is open.
- R5: A slow-bus write in the window does one read request and then one write request (`mem_we` high) to the same word address. The written word equals the read word with lane A[1:0] replaced by the slow-bus data; the other three lanes keep their values.
- R6: While `mem_stb` is high and `mem_stall` is high, the next cycle still has `mem_stb` high, with address, `mem_we` and `mem_wdata` unchanged.
- R7: `mem_cyc` stays high from the first request until the final acknowledge. No request is issued while an acknowledge is outstanding, and `mem_cyc` falls only in the cycle after an acknowledge.
- R8: Each strobe-high phase produces exactly one transaction. A read has one accepted request; a write has two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_phi2 | input | 1 | Slow-bus phase strobe (asynchronous) |
| cpu_addr | input | CPU_AW | Slow-bus address |
| cpu_data_in | input | 8 | Slow-bus write data |
| cpu_rw | input | 1 | Slow-bus direction: 1 read, 0 write |
| cpu_data_out | output | 8 | Read byte returned to slow bus |
| cpu_data_oe | output | 1 | Drive enable for `cpu_data_out` |
| cfg_cyc | input | 1 | Config port cycle |
| cfg_stb | input | 1 | Config port strobe |
| cfg_we | input | 1 | Config port write enable |
| cfg_wdata | input | AW | Config write data (base address) |
| cfg_rdata | output | AW | Config read data (base address) |
| cfg_ack | output | 1 | Config acknowledge |
| mem_cyc | output | 1 | Memory bus cycle |
| mem_stb | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write enable |
| mem_adr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_stall | input | 1 | Memory stall |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions assume two things about the slow bus. Its address, data and direction stay stable across each strobe-high phase. Its phases are long enough for a full read-modify-write, including stalls, to finish before the next rising strobe; the go-while-idle check relies on this. They also assume the memory acknowledges each accepted request exactly once. The bench's memory model keeps a single request outstanding, with stall at most a few cycles in a row and latency of one to four cycles. Its strobe phases are forty cycles high and thirty low, which leaves ample margin.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int DW = 32;
  localparam int LANES = DW / 8;

  typedef enum logic [2:0] {
    M_IDLE,
    M_RD_REQ,
    M_RD_WAIT,
    M_WR_REQ,
    M_WR_WAIT
  } mst_state_t;

  function automatic logic [7:0] lane_get(input logic [DW-1:0] w, input logic [1:0] lane);
    return w[lane*8 +: 8];
  endfunction

  function automatic logic [DW-1:0] lane_put(input logic [DW-1:0] w, input logic [1:0] lane,
                                             input logic [7:0] b);
    logic [DW-1:0] r;
    r = w;
    r[lane*8 +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/rwb_capture.sv
module rwb_capture #(
  parameter int CPU_AW = 16,
  parameter int SYNC = 2,
  parameter logic [CPU_AW-1:0] WIN_LO = 16'h8000,
  parameter int WIN_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                phi2,
  input  logic [CPU_AW-1:0]   addr,
  input  logic [7:0]          din,
  input  logic                rw,
  output logic                phi2_s,
  output logic                go,
  output logic                go_write,
  output logic [WIN_BITS-1:0] go_off,
  output logic [7:0]          go_data
);
  logic [SYNC-1:0] sh_q;
  logic            phi2_d_q;
  logic [CPU_AW:0] rel;
  logic            hit, rise;

  assign phi2_s = sh_q[SYNC-1];
  assign rise   = phi2_s & ~phi2_d_q;
  assign rel    = {1'b0, addr} - {1'b0, WIN_LO};
  assign hit    = ~rel[CPU_AW] && (rel[CPU_AW-1:WIN_BITS] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      phi2_d_q <= 1'b0;
      go       <= 1'b0;
    end else begin
      sh_q     <= {sh_q[SYNC-2:0], phi2};
      phi2_d_q <= phi2_s;
      go       <= rise & hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rise) begin
      go_write <= ~rw;
      go_off   <= rel[WIN_BITS-1:0];
      go_data  <= din;
    end
  end

  p_single_go_r8: assert property (@(posedge clk) disable iff (!rst_n) go |=> !go);
endmodule

// File: rtl/rwb_base_reg.sv
module rwb_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic          ack,
  output logic [AW-3:0] base_word
);
  logic req, wr_en;
  logic unused_lo;

  assign unused_lo = ^wdata[1:0];
  assign req   = cyc & stb & ~ack;
  assign wr_en = req & we;
  assign rdata = {base_word, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack       <= 1'b0;
      base_word <= '0;
    end else begin
      ack <= req;
      if (wr_en) base_word <= wdata[AW-1:2];
    end
  end

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
endmodule

// File: rtl/rwb_master.sv
module rwb_master
  import rwb_pkg::*;
#(
  parameter int AW = 32,
  parameter int WIN_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                go_write,
  input  logic [WIN_BITS-1:0] go_off,
  input  logic [7:0]          go_data,
  input  logic [AW-3:0]       base_word,
  output logic                busy,
  output logic                rd_valid,
  output logic [7:0]          rd_byte,
  output logic                mem_cyc,
  output logic                mem_stb,
  output logic                mem_we,
  output logic [AW-1:0]       mem_adr,
  output logic [DW-1:0]       mem_wdata,
  input  logic                mem_stall,
  input  logic                mem_ack,
  input  logic [DW-1:0]       mem_rdata
);
  localparam int PAD = AW - WIN_BITS;

  mst_state_t    st_q, st_n;
  logic [AW-3:0] wadr_q, wadr_n;
  logic [1:0]    lane_q, lane_n;
  logic [7:0]    byte_q, byte_n, rdb_q, rdb_n;
  logic          wr_q, wr_n, vld_q, vld_n;
  logic [DW-1:0] word_q, word_n;

  always_comb begin
    st_n   = st_q;
    wadr_n = wadr_q;
    lane_n = lane_q;
    byte_n = byte_q;
    wr_n   = wr_q;
    word_n = word_q;
    rdb_n  = rdb_q;
    vld_n  = 1'b0;
    case (st_q)
      M_IDLE: if (go) begin
        st_n   = M_RD_REQ;
        wadr_n = base_word + {{PAD{1'b0}}, go_off[WIN_BITS-1:2]};
        lane_n = go_off[1:0];
        byte_n = go_data;
        wr_n   = go_write;
      end
      M_RD_REQ: if (!mem_stall) st_n = M_RD_WAIT;
      M_RD_WAIT: if (mem_ack) begin
        if (wr_q) begin
          word_n = lane_put(mem_rdata, lane_q, byte_q);
          st_n   = M_WR_REQ;
        end else begin
          rdb_n = lane_get(mem_rdata, lane_q);
          vld_n = 1'b1;
          st_n  = M_IDLE;
        end
      end
      M_WR_REQ: if (!mem_stall) st_n = M_WR_WAIT;
      M_WR_WAIT: if (mem_ack) st_n = M_IDLE;
      default: st_n = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_IDLE;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk) begin
    wadr_q <= wadr_n;
    lane_q <= lane_n;
    byte_q <= byte_n;
    wr_q   <= wr_n;
    word_q <= word_n;
    rdb_q  <= rdb_n;
  end

  assign busy      = (st_q != M_IDLE);
  assign mem_cyc   = busy;
  assign mem_stb   = (st_q == M_RD_REQ) || (st_q == M_WR_REQ);
  assign mem_we    = (st_q == M_WR_REQ);
  assign mem_adr   = {wadr_q, 2'b00};
  assign mem_wdata = word_q;
  assign rd_valid  = vld_q;
  assign rd_byte   = rdb_q;

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_stb && mem_stall) |=> (mem_stb && $stable(mem_adr) && $stable(mem_we) && $stable(mem_wdata)));
  p_cyc_end_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cyc) |-> $past(mem_ack));
  p_write_in_open_cyc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_stb && mem_we) |-> $past(mem_cyc));
endmodule

// File: rtl/retro_window_bridge.sv
module retro_window_bridge #(
  parameter int CPU_AW = 16,
  parameter int AW = 32,
  parameter int SYNC = 2,
  parameter logic [CPU_AW-1:0] WIN_LO = 16'h8000,
  parameter int WIN_BITS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_phi2,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_data_in,
  input  logic              cpu_rw,
  output logic [7:0]        cpu_data_out,
  output logic              cpu_data_oe,
  input  logic              cfg_cyc,
  input  logic              cfg_stb,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  output logic              cfg_ack,
  output logic              mem_cyc,
  output logic              mem_stb,
  output logic              mem_we,
  output logic [AW-1:0]     mem_adr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_stall,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  logic                phi2_s, go, go_write, busy, rd_valid, oe_q, oe_n;
  logic [WIN_BITS-1:0] go_off;
  logic [7:0]          go_data, rd_byte;
  logic [AW-3:0]       base_word;

  rwb_capture #(.CPU_AW(CPU_AW), .SYNC(SYNC), .WIN_LO(WIN_LO), .WIN_BITS(WIN_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .phi2(cpu_phi2), .addr(cpu_addr), .din(cpu_data_in),
    .rw(cpu_rw), .phi2_s(phi2_s), .go(go), .go_write(go_write), .go_off(go_off),
    .go_data(go_data));

  rwb_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .cyc(cfg_cyc), .stb(cfg_stb), .we(cfg_we),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ack(cfg_ack), .base_word(base_word));

  rwb_master #(.AW(AW), .WIN_BITS(WIN_BITS)) u_mst (
    .clk(clk), .rst_n(rst_n), .go(go), .go_write(go_write), .go_off(go_off),
    .go_data(go_data), .base_word(base_word), .busy(busy), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .mem_cyc(mem_cyc), .mem_stb(mem_stb), .mem_we(mem_we),
    .mem_adr(mem_adr), .mem_wdata(mem_wdata), .mem_stall(mem_stall),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always_comb begin
    oe_n = oe_q;
    if (rd_valid)    oe_n = 1'b1;
    else if (!phi2_s) oe_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_n;
  end

  assign cpu_data_oe  = oe_q;
  assign cpu_data_out = rd_byte;

  p_oe_no_cyc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_data_oe |-> !mem_cyc);
  p_go_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
endmodule

// File: tb/retro_window_bridge_test.sv
module retro_window_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_phi2 = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data_in = '0;
  logic        cpu_rw = 1'b1;
  logic [7:0]  cpu_data_out;
  logic        cpu_data_oe;
  logic        cfg_cyc = 1'b0, cfg_stb = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_ack;
  logic        mem_cyc, mem_stb, mem_we;
  logic [31:0] mem_adr, mem_wdata;
  logic        mem_stall, mem_ack;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  retro_window_bridge uut (.*);

  // memory model
  logic [31:0] mem [512];
  logic [31:0] shadow [512];
  logic        stall_en = 1'b0;
  logic [7:0]  tick;
  logic        pend, pend_we;
  logic [8:0]  pend_idx;
  logic [1:0]  wait_cnt;
  int          acc_rd, acc_wr, hold_viol, pend_viol, stall_seen;
  logic [31:0] last_adr, prev_adr, prev_wd;
  logic        prev_hold, prev_we;

  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h01030507) ^ 32'hA5C3_0F96;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_word(i);
      tick <= '0; pend <= 1'b0; mem_ack <= 1'b0; mem_stall <= 1'b0; mem_rdata <= '0;
      acc_rd <= 0; acc_wr <= 0; hold_viol <= 0; pend_viol <= 0; stall_seen <= 0;
      prev_hold <= 1'b0; last_adr <= '0; wait_cnt <= '0; pend_idx <= '0; pend_we <= 1'b0;
      prev_adr <= '0; prev_wd <= '0; prev_we <= 1'b0;
    end else begin
      tick <= tick + 8'd1;
      mem_ack <= 1'b0;
      mem_stall <= stall_en && (tick[1:0] == 2'b01 || tick[2:0] == 3'b110);
      if (mem_stb && mem_stall) stall_seen <= stall_seen + 1;
      // R6 monitor
      if (prev_hold && !(mem_stb && mem_adr == prev_adr && mem_we == prev_we && mem_wdata == prev_wd))
        hold_viol <= hold_viol + 1;
      prev_hold <= mem_stb && mem_stall;
      prev_adr <= mem_adr; prev_we <= mem_we; prev_wd <= mem_wdata;
      // R7 monitor
      if ((pend && mem_stb) || (pend && !mem_cyc)) pend_viol <= pend_viol + 1;
      if (pend) begin
        if (wait_cnt == 2'd0) begin
          mem_ack <= 1'b1;
          mem_rdata <= pend_we ? 32'h0 : mem[pend_idx];
          pend <= 1'b0;
        end else wait_cnt <= wait_cnt - 2'd1;
      end
      if (mem_cyc && mem_stb && !mem_stall) begin
        pend <= 1'b1; pend_we <= mem_we; pend_idx <= mem_adr[10:2];
        wait_cnt <= tick[1:0]; last_adr <= mem_adr;
        if (mem_we) begin mem[mem_adr[10:2]] <= mem_wdata; acc_wr <= acc_wr + 1; end
        else acc_rd <= acc_rd + 1;
      end
    end
  end

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] cfg_seen;
  task automatic cfg_access(input logic we, input logic [31:0] d);
    @(negedge clk);
    cfg_cyc = 1'b1; cfg_stb = 1'b1; cfg_we = we; cfg_wdata = d;
    @(negedge clk);
    chk("R2 ack", {31'b0, cfg_ack}, 32'd1);
    cfg_seen = cfg_rdata;
    cfg_cyc = 1'b0; cfg_stb = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk("R2 ack single", {31'b0, cfg_ack}, 32'd0);
  endtask

  int s_rd, s_wr;
  logic s_oe, s_oe_after;
  logic [7:0] s_byte;
  task automatic cpu_cycle(input logic [15:0] a, input logic [7:0] d, input logic rd);
    cpu_addr = a; cpu_data_in = d; cpu_rw = rd; cpu_phi2 = 1'b0;
    repeat (24) @(negedge clk);
    s_rd = acc_rd; s_wr = acc_wr;
    cpu_phi2 = 1'b1;
    repeat (36) @(negedge clk);
    s_oe = cpu_data_oe; s_byte = cpu_data_out;
    repeat (4) @(negedge clk);
    cpu_phi2 = 1'b0;
    repeat (6) @(negedge clk);
    s_oe_after = cpu_data_oe;
    s_rd = acc_rd - s_rd; s_wr = acc_wr - s_wr;
  endtask

  logic [31:0] base;
  logic [31:0] exp_adr;
  logic [15:0] a;
  logic [7:0]  d;
  int          idx, bad_words;

  initial begin
    for (int i = 0; i < 512; i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mem_cyc", {31'b0, mem_cyc}, 32'd0);
    chk("R1 mem_stb", {31'b0, mem_stb}, 32'd0);
    chk("R1 oe", {31'b0, cpu_data_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cfg_access(1'b0, 32'h0);
    chk("R1 base after reset", cfg_seen, 32'h0);

    for (int b = 0; b < 2; b++) begin
      for (int se = 0; se < 2; se++) begin
        stall_en = se[0];
        base = (b == 0) ? 32'h0000_0403 : 32'h0001_2A0E;
        cfg_access(1'b1, base);
        cfg_access(1'b0, 32'h0);
        chk("R2 base readback", cfg_seen, base & 32'hFFFF_FFFC);
        for (int reg_i = 0; reg_i < 2; reg_i++) begin
          for (int o = 0; o < 16; o++) begin
            a = (reg_i == 0) ? (16'h8000 + 16'(o)) : (16'hFFF0 + 16'(o));
            d = 8'(o * 37 + b * 91 + se * 13 + reg_i * 5 + 1);
            exp_adr = ((base & 32'hFFFF_FFFC) + {16'h0, a - 16'h8000}) & 32'hFFFF_FFFC;
            idx = int'(exp_adr[10:2]);
            // write
            cpu_cycle(a, d, 1'b0);
            shadow[idx][a[1:0]*8 +: 8] = d;
            chk("R5 one read", s_rd, 1);
            chk("R5 one write", s_wr, 1);
            chk("R5 write address", last_adr, exp_adr);
            chk("R5 merged word", mem[idx], shadow[idx]);
            chk("R5 no drive on write", {31'b0, s_oe}, 32'd0);
            // read
            cpu_cycle(a, 8'h00, 1'b1);
            chk("R8 read one request", s_rd, 1);
            chk("R4 no write on read", s_wr, 0);
            chk("R4 read address", last_adr, exp_adr);
            chk("R4 drive enable", {31'b0, s_oe}, 32'd1);
            chk("R4 byte lane", {24'b0, s_byte}, {24'b0, shadow[idx][a[1:0]*8 +: 8]});
            chk("R4 release after strobe", {31'b0, s_oe_after}, 32'd0);
          end
        end
      end
    end

    // R3 outside window
    for (int k = 0; k < 4; k++) begin
      a = (k == 0) ? 16'h0000 : (k == 1) ? 16'h7FFF : (k == 2) ? 16'h1234 : 16'h7FFC;
      cpu_cycle(a, 8'h5A, 1'b0);
      chk("R3 outside write no read", s_rd, 0);
      chk("R3 outside write no write", s_wr, 0);
      cpu_cycle(a, 8'h00, 1'b1);
      chk("R3 outside read no request", s_rd + s_wr, 0);
      chk("R3 outside read no drive", {31'b0, s_oe}, 32'd0);
    end
    bad_words = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== shadow[i]) bad_words++;
    chk("R3 R5 memory image", bad_words, 0);
    chk("R6 stall hold", hold_viol, 0);
    chk("R6 stalls exercised", {31'b0, stall_seen > 0}, 32'd1);
    chk("R7 no request while pending", pend_viol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule